// File: doc/BRIEF.md
# Flash Code Protection Controller

This block keeps the protection configuration byte of an on-chip flash array and decides whether the parallel programming port may read or rewrite that array. The byte behaves like nonvolatile storage. It comes up as all ones. A program operation can only turn ones into zeros. A block erase is the only way to bring the whole byte back to all ones.

Two 2-bit fields in the byte together decide whether the array is locked:

- A "release" field in bits 5:4. When it is zero, protection is off.
- A "level" field in bits 7:6. While the release field is nonzero, the array is locked unless the level field reads 11.

The lock applies only while the port runs in parallel mode. The release field also cannot be altered from that mode.

The surrounding programmer logic does three things with this block:

- It presents the current port mode.
- It pulses single-cycle program or erase strobes with a data byte.
- It consults the allow output before serving a parallel-mode array request.

The stored byte is brought out so that the programmer can read back the protection state.

Top module: `flash_guard`

## Requirements
- R1: After reset the stored byte reads 8'hFF, and in parallel mode (mode code 2'b10) access is allowed.
- R2: A program strobe without erase, issued in mode 2'b00, 2'b01 or 2'b11, makes the stored byte equal to the old byte ANDed with the data byte, with bits 3:0 excepted per R5. The change is visible one cycle later.
- R3: Programming never sets a bit: a bit that reads 0 still reads 0 after any program strobe.
- R4: An erase strobe makes the byte 8'hFF one cycle later, and an erase wins over a program strobe in the same cycle.
- R5: Bits 3:0 always read 1. A program that tries to clear them leaves them unchanged.
- R6: In parallel mode (2'b10) a program strobe leaves bits 5:4 unchanged, while bits 7:6 still clear as in R2.
- R7: When bits 5:4 read 00, access is allowed in parallel mode whatever bits 7:6 hold.
- R8: When bits 5:4 are nonzero and bits 7:6 are 00, 01 or 10, access is refused in parallel mode.
- R9: When bits 7:6 read 11, access is allowed in parallel mode whatever bits 5:4 hold.
- R10: In any mode other than 2'b10, access is allowed regardless of the stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the shipped byte 8'hFF |
| mode_i | input | 2 | Port mode: 2'b10 parallel, 2'b01 serial, 2'b00/2'b11 other |
| prog_i | input | 1 | Single-cycle program strobe |
| erase_i | input | 1 | Single-cycle block erase strobe |
| data_i | input | 8 | Data byte for a program strobe |
| cfg_o | output | 8 | Stored protection byte |
| access_ok_o | output | 1 | Parallel-mode array access allowed (combinational) |

## Verification
The hardest state to reach is the one where the release field is cleared while the level field still locks. The port can never clear the release field itself, because programs issued in parallel mode leave it alone. The stimulus therefore erases the byte first. It then programs each of the sixteen field combinations from serial mode, and only afterwards switches to parallel mode to sample the access decision. A separate sequence programs all zeros from parallel mode, to show that the level field clears while the release field survives.

// File: rtl/fguard_pkg.sv
package fguard_pkg;

  localparam int CFG_W = 8;
  localparam int RSV_W = 4;
  localparam int FLD_W = 2;

  typedef enum logic [1:0] {
    MODE_OTHER    = 2'b00,
    MODE_SERIAL   = 2'b01,
    MODE_PARALLEL = 2'b10,
    MODE_SPARE    = 2'b11
  } port_mode_e;

  typedef struct packed {
    logic [FLD_W-1:0] level;
    logic [FLD_W-1:0] rclr;
    logic [RSV_W-1:0] rsv;
  } cfg_t;

  localparam logic [FLD_W-1:0] LVL_OPEN = '1;
  localparam logic [FLD_W-1:0] RCLR_OFF = '0;

  // New byte after a program strobe: bits may only clear, reserved bits stay set,
  // and the release field is frozen while field_lock is high.
  function automatic cfg_t next_on_program(cfg_t cur, logic [CFG_W-1:0] wr,
                                           logic field_lock);
    cfg_t n;
    n     = cfg_t'(cur & wr);
    n.rsv = cur.rsv;
    if (field_lock) n.rclr = cur.rclr;
    return n;
  endfunction

  // Protection is active when the release field is nonzero and the level field is not open.
  function automatic logic is_protected(cfg_t c);
    return (c.rclr != RCLR_OFF) && (c.level != LVL_OPEN);
  endfunction

endpackage

// File: rtl/fguard_store.sv
module fguard_store
  import fguard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_fire,
  input  logic             erase_fire,
  input  logic             field_lock,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '1;
    end else if (erase_fire) begin
      cfg_q <= '1;
    end else if (prog_fire) begin
      cfg_q <= next_on_program(cfg_q, wr_data, field_lock);
    end
  end

endmodule

// File: rtl/fguard_decode.sv
module fguard_decode
  import fguard_pkg::*;
(
  input  cfg_t cfg,
  output logic protect_on
);

  always_comb begin
    protect_on = is_protected(cfg);
  end

endmodule

// File: rtl/fguard_gate.sv
module fguard_gate
  import fguard_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       protect_on,
  output logic       par_mode,
  output logic       access_ok
);

  always_comb begin
    par_mode  = (mode == MODE_PARALLEL);
    access_ok = !(par_mode && protect_on);
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       prog_i,
  input  logic       erase_i,
  input  logic [7:0] data_i,
  output logic [7:0] cfg_o,
  output logic       access_ok_o
);

  // named internal events for the checker
  logic prog_fire;
  logic erase_fire;
  logic field_lock;
  logic protect_on;
  cfg_t cfg_q;

  assign erase_fire = erase_i;
  assign prog_fire  = prog_i && !erase_i;

  fguard_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_fire  (prog_fire),
    .erase_fire (erase_fire),
    .field_lock (field_lock),
    .wr_data    (data_i),
    .cfg_q      (cfg_q)
  );

  fguard_decode u_decode (
    .cfg        (cfg_q),
    .protect_on (protect_on)
  );

  fguard_gate u_gate (
    .mode       (mode_i),
    .protect_on (protect_on),
    .par_mode   (field_lock),
    .access_ok  (access_ok_o)
  );

  assign cfg_o = cfg_q;

endmodule

// File: rtl/fguard_checker.sv
module fguard_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       erase_i,
  input logic [7:0] cfg_o,
  input logic       access_ok_o,
  input logic       prog_fire,
  input logic       field_lock
);

  AST_RESERVED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[3:0] == 4'hF); // R5

  AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_i |=> ((cfg_o & ~$past(cfg_o)) == 8'h00)); // R3

  AST_ERASE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> cfg_o == 8'hFF); // R4

  AST_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_fire && field_lock) |=> cfg_o[5:4] == $past(cfg_o[5:4])); // R6

  AST_OTHER_MODE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b10) |-> access_ok_o); // R10

  AST_LOCKED_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && cfg_o[5:4] != 2'b00 && cfg_o[7:6] != 2'b11) |-> !access_ok_o); // R8

  AST_RELEASED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[5:4] == 2'b00) |-> access_ok_o); // R7

endmodule

bind flash_guard fguard_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .erase_i     (erase_i),
  .cfg_o       (cfg_o),
  .access_ok_o (access_ok_o),
  .prog_fire   (prog_fire),
  .field_lock  (field_lock)
);

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       prog_i = 1'b0;
  logic       erase_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] cfg_o;
  logic       access_ok_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] model = 8'hFF;

  always #5 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .prog_i(prog_i),
    .erase_i(erase_i), .data_i(data_i), .cfg_o(cfg_o), .access_ok_o(access_ok_o)
  );

  // bench-side restatement: per-bit view of a program
  function automatic logic [7:0] model_prog(logic [7:0] old, logic [7:0] d, logic par);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) begin
      if (b < 4)                  r[b] = 1'b1;
      else if (par && (b == 4 || b == 5)) r[b] = old[b];
      else                        r[b] = old[b] & d[b];
    end
    return r;
  endfunction

  function automatic logic model_ok(logic [7:0] c, logic [1:0] m);
    if (m != 2'b10) return 1'b1;
    if (c[5:4] == 2'b00) return 1'b1;
    return c[7:6] == 2'b11;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_prog(logic [7:0] d, logic [1:0] m);
    @(negedge clk);
    mode_i = m; data_i = d; prog_i = 1'b1;
    @(negedge clk);
    prog_i = 1'b0;
    model = model_prog(model, d, m == 2'b10);
  endtask

  task automatic do_erase();
    @(negedge clk);
    erase_i = 1'b1;
    @(negedge clk);
    erase_i = 1'b0;
    model = 8'hFF;
  endtask

  task automatic t_reset();
    mode_i = 2'b10; #1;
    check("R1 cfg", cfg_o, 8'hFF);
    check("R1 access", {7'b0, access_ok_o}, 8'h01);
  endtask

  task automatic t_program();
    do_prog(8'hB7, 2'b01);
    check("R2 and", cfg_o, model);
    check("R2 value", cfg_o, 8'hBF);
    do_prog(8'h7F, 2'b00);
    check("R2 other mode", cfg_o, 8'h3F);
    do_prog(8'hFF, 2'b11);
    check("R3 no set", cfg_o, 8'h3F);
  endtask

  task automatic t_erase();
    do_erase();
    check("R4 erase", cfg_o, 8'hFF);
    do_prog(8'h00, 2'b01);
    check("R4 setup", cfg_o, 8'h0F);
    @(negedge clk);
    mode_i = 2'b01; data_i = 8'h00; prog_i = 1'b1; erase_i = 1'b1;
    @(negedge clk);
    prog_i = 1'b0; erase_i = 1'b0; model = 8'hFF;
    check("R4 priority", cfg_o, 8'hFF);
  endtask

  task automatic t_reserved();
    do_erase();
    do_prog(8'hF0, 2'b01);
    check("R5 reserved", cfg_o, 8'hFF);
    do_prog(8'hF5, 2'b10);
    check("R5 reserved par", cfg_o, 8'hFF);
  endtask

  task automatic t_par_lock();
    do_erase();
    do_prog(8'h00, 2'b10);
    check("R6 frozen", cfg_o, 8'h3F);
    check("R8 level00", {7'b0, access_ok_o}, 8'h00);
    do_prog(8'hCF, 2'b01);
    check("R6 serial clears", cfg_o, 8'h0F);
    mode_i = 2'b10; #1;
    check("R7 released", {7'b0, access_ok_o}, 8'h01);
  endtask

  task automatic t_decode();
    for (int rc = 0; rc < 4; rc++) begin
      for (int lv = 0; lv < 4; lv++) begin
        logic [7:0] v;
        v = {lv[1:0], rc[1:0], 4'hF};
        do_erase();
        do_prog(v, 2'b01);
        check("R2 field set", cfg_o, v);
        mode_i = 2'b10; #1;
        if (rc == 0)       check("R7 table", {7'b0, access_ok_o}, {7'b0, model_ok(v, 2'b10)});
        else if (lv == 3)  check("R9 table", {7'b0, access_ok_o}, 8'h01);
        else               check("R8 table", {7'b0, access_ok_o}, 8'h00);
        for (int m = 0; m < 4; m++) begin
          if (m != 2) begin
            mode_i = m[1:0]; #1;
            check("R10 open", {7'b0, access_ok_o}, 8'h01);
          end
        end
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_reserved();
    t_par_lock();
    t_decode();
    finish_run();
  end

endmodule